// File: doc/BRIEF.md
# AAL5 Frame Delimiting Receiver

The receiver takes a stream of ATM cells that belong to one virtual channel and whose header checksum has already been verified. It turns that stream into a word stream for an application that works on whole frames. The application never sees cell boundaries. It sees three qualifiers instead: a start-of-frame flag, an end-of-frame flag and a data-enable flag.

Each cell arrives as thirteen 32-bit words: one header word followed by twelve payload words. The receiver strips the headers. It buffers cell payloads so that padding can be found and dropped once the length field of the final cell is known. After the last payload word it forwards the two trailer words unchanged. The CRC-32 of the frame is checked, and a bad CRC or an impossible length is reported with a flag on the final trailer word.

A typical user sits between a cell-level switch port and a packet-processing engine. That engine reads payload words while data-enable is high and copies the two trailer words that follow end-of-frame.

Top module: `aal5rx_frame_rx`

## Requirements
- R1: After reset, out_valid, out_sof, out_eof, out_den and out_err are all low.
- R2: A cell is a header word marked by in_soc, followed by twelve payload words with octets big-endian in each word. Bit 1 of the header word set to 1 marks the last cell of a frame. Cells with that bit at 0 never end a frame.
- R3: Every word that holds payload octets is output in order with out_valid and out_den high, across cell boundaries. out_sof is high on the first of these words only.
- R4: out_eof is high, together with out_den, on payload word number ceil(L/4)-1 of the frame, counting from 0. L is bits 15:0 of payload word 10 of the last cell.
- R5: Words that hold only padding are not output (out_valid low). A payload word that ends in padding octets is output whole.
- R6: The two words that follow end-of-frame are exactly payload words 10 and 11 of the last cell, unchanged, with out_valid high and out_den low. No other word comes between them and the end-of-frame word.
- R7: out_err is high on the second trailer word when the CRC-32 of the frame is wrong. The CRC uses polynomial 0x04C11DB7 and an all-ones start value, runs most significant bit first, and is inverted at the end. It covers every payload octet of every cell in the frame except the last four, and it is carried in payload word 11 of the last cell.
- R8: out_err is high on the second trailer word when L is greater than 48*C-8, where C is the number of cells in the frame. In that case only the 12*C-2 words before the trailer are output as payload, and end-of-frame marks the last of them.
- R9: Frames sent back to back, one word per cycle with no idle cycles, all come out complete and in order. Idle cycles with in_valid low inside a cell do not change the output.
- R10: When the payload ends inside the cell before the last one, end-of-frame is raised in that cell's words, and the last cell contributes only its two trailer words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word is valid |
| in_soc | input | 1 | Input word is a cell header |
| in_data | input | 32 | Input cell word |
| out_valid | output | 1 | Output word is valid |
| out_sof | output | 1 | First payload word of a frame |
| out_eof | output | 1 | Last payload word of a frame |
| out_den | output | 1 | Output word carries frame payload |
| out_err | output | 1 | CRC or length error, on the second trailer word |
| out_data | output | 32 | Output word |

## Verification
Three single-cell frames separate the cases of a full-word payload that ends exactly at the trailer, a payload that ends partway through a word with padding words to drop, and a length field that claims more octets than arrived. Multi-cell frames show whether cell headers are hidden and payload runs on across cell boundaries. A 41-octet frame puts end-of-frame in the next-to-last cell. A corrupted payload octet tells a real CRC check apart from one that only looks at the length. Finally, a gap-free train of frames of mixed sizes and a frame sent with idle cycles inside its cells show whether the cell buffering keeps up at full rate and does not depend on input timing.

// File: rtl/aal5rx_pkg.sv
package aal5rx_pkg;

    localparam int CELL_WORDS = 12;
    localparam int TRL_A      = CELL_WORDS - 2;
    localparam int TRL_B      = CELL_WORDS - 1;
    localparam int IDX_W      = 4;

    localparam logic [31:0] CRC_POLY    = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_RESIDUE = 32'hC704_DD7B;

    typedef enum logic [1:0] {
        S_FREE  = 2'd0,
        S_FILL  = 2'd1,
        S_HELD  = 2'd2,
        S_READY = 2'd3
    } slot_st_e;

    typedef struct packed {
        logic             first;
        logic             last;
        logic             has_eof;
        logic             err;
        logic [IDX_W-1:0] pw;
    } slot_meta_t;

    function automatic logic [31:0] crc32_step(input logic [31:0] c,
                                               input logic [31:0] d);
        logic [31:0] r;
        logic        fb;
        r = c;
        for (int i = 31; i >= 0; i--) begin
            fb = r[31] ^ d[i];
            r  = {r[30:0], 1'b0} ^ (fb ? CRC_POLY : 32'h0);
        end
        return r;
    endfunction

endpackage

// File: rtl/aal5rx_crc32.sv
module aal5rx_crc32
    import aal5rx_pkg::*;
(
    input  logic [31:0] crc_i,
    input  logic [31:0] data_i,
    output logic [31:0] crc_o
);
    always_comb begin
        crc_o = crc32_step(crc_i, data_i);
    end
endmodule

// File: rtl/aal5rx_cell_store.sv
module aal5rx_cell_store
    import aal5rx_pkg::*;
#(
    parameter int NSLOT  = 3,
    parameter int SLOT_W = 2
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [SLOT_W-1:0] wslot_i,
    input  logic [IDX_W-1:0]  widx_i,
    input  logic [31:0]       wdata_i,
    input  logic [SLOT_W-1:0] rslot_i,
    input  logic [IDX_W-1:0]  ridx_i,
    output logic [31:0]       rdata_o
);
    localparam int DEPTH  = NSLOT * CELL_WORDS;
    localparam int ADDR_W = $clog2(DEPTH);

    logic [31:0]       mem_q [DEPTH];
    logic [ADDR_W-1:0] waddr, raddr;

    always_comb begin
        waddr   = ADDR_W'(wslot_i) * ADDR_W'(CELL_WORDS) + ADDR_W'(widx_i);
        raddr   = ADDR_W'(rslot_i) * ADDR_W'(CELL_WORDS) + ADDR_W'(ridx_i);
        rdata_o = mem_q[raddr];
    end

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[waddr] <= wdata_i;
        end
    end
endmodule

// File: rtl/aal5rx_reader.sv
module aal5rx_reader
    import aal5rx_pkg::*;
#(
    parameter int NSLOT  = 3,
    parameter int SLOT_W = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NSLOT-1:0]             ready_i,
    input  slot_meta_t [NSLOT-1:0]       meta_i,
    input  logic [31:0]                  rdata_i,
    output logic [SLOT_W-1:0]            rslot_o,
    output logic [IDX_W-1:0]             ridx_o,
    output logic                         done_o,
    output logic                         out_valid,
    output logic                         out_sof,
    output logic                         out_eof,
    output logic                         out_den,
    output logic                         out_err,
    output logic [31:0]                  out_data
);
    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic [IDX_W-1:0]  idx;
        logic              valid;
        logic              sof;
        logic              eof;
        logic              den;
        logic              err;
        logic [31:0]       data;
    } rd_t;

    rd_t        rd_d, rd_q;
    slot_meta_t m;
    logic       cur_rdy;

    always_comb begin
        rd_d    = rd_q;
        m       = meta_i[rd_q.slot];
        cur_rdy = ready_i[rd_q.slot];
        done_o  = 1'b0;
        rd_d.valid = 1'b0;
        rd_d.sof   = 1'b0;
        rd_d.eof   = 1'b0;
        rd_d.den   = 1'b0;
        rd_d.err   = 1'b0;
        if (cur_rdy) begin
            rd_d.den   = rd_q.idx < m.pw;
            rd_d.valid = rd_d.den || (m.last && rd_q.idx >= IDX_W'(TRL_A));
            rd_d.sof   = m.first && rd_q.idx == '0 && rd_d.den;
            rd_d.eof   = m.has_eof && rd_d.den && rd_q.idx == m.pw - 4'd1;
            rd_d.err   = m.last && m.err && rd_q.idx == IDX_W'(TRL_B);
            rd_d.data  = rdata_i;
            if (rd_q.idx == IDX_W'(TRL_B)) begin
                done_o    = 1'b1;
                rd_d.idx  = '0;
                rd_d.slot = (rd_q.slot == SLOT_W'(NSLOT - 1)) ? '0 : rd_q.slot + 1'b1;
            end else begin
                rd_d.idx = rd_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rslot_o   = rd_q.slot;
    assign ridx_o    = rd_q.idx;
    assign out_valid = rd_q.valid;
    assign out_sof   = rd_q.sof;
    assign out_eof   = rd_q.eof;
    assign out_den   = rd_q.den;
    assign out_err   = rd_q.err;
    assign out_data  = rd_q.data;

    assert_eof_with_den_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_eof |-> (out_den && out_valid));
    assert_den_is_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_den |-> out_valid);
    assert_err_on_trailer_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> (out_valid && !out_den && !out_sof));
    assert_trailer_follows_eof_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_eof |=> !out_den);
endmodule

// File: rtl/aal5rx_frame_rx.sv
module aal5rx_frame_rx
    import aal5rx_pkg::*;
#(
    parameter int NSLOT = 3,
    parameter int LEN_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic        in_soc,
    input  logic [31:0] in_data,
    output logic        out_valid,
    output logic        out_sof,
    output logic        out_eof,
    output logic        out_den,
    output logic        out_err,
    output logic [31:0] out_data
);
    localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;
    localparam int FW_W   = LEN_W;
    localparam int CW     = FW_W + 3;

    typedef struct packed {
        logic [IDX_W-1:0]        wc;
        logic [SLOT_W-1:0]       wslot;
        logic                    in_cell;
        logic                    cell_last;
        logic                    frame_start;
        logic [31:0]             crc;
        logic [FW_W-1:0]         fw;
        logic [LEN_W-1:0]        len;
        logic [SLOT_W-1:0]       held;
        logic                    held_vld;
        slot_st_e [NSLOT-1:0]    st;
        slot_meta_t [NSLOT-1:0]  meta;
    } ctl_t;

    ctl_t               ctl_d, ctl_q;
    logic [31:0]        crc_nx;
    logic               mem_we;
    logic [NSLOT-1:0]   rdy;
    logic [SLOT_W-1:0]  rd_slot;
    logic [IDX_W-1:0]   rd_idx;
    logic               rd_done;
    logic [31:0]        rd_data;
    logic [CW-1:0]      p_w, fw_w, d_last, d_pen;
    logic [IDX_W-1:0]   pw_last, pw_pen;
    logic               len_big, crc_bad;

    aal5rx_crc32 crc_i (
        .crc_i  (ctl_q.crc),
        .data_i (in_data),
        .crc_o  (crc_nx)
    );

    aal5rx_cell_store #(.NSLOT(NSLOT), .SLOT_W(SLOT_W)) store_i (
        .clk     (clk),
        .we_i    (mem_we),
        .wslot_i (ctl_q.wslot),
        .widx_i  (ctl_q.wc),
        .wdata_i (in_data),
        .rslot_i (rd_slot),
        .ridx_i  (rd_idx),
        .rdata_o (rd_data)
    );

    for (genvar g = 0; g < NSLOT; g++) begin : g_rdy
        assign rdy[g] = (ctl_q.st[g] == S_READY);
    end

    aal5rx_reader #(.NSLOT(NSLOT), .SLOT_W(SLOT_W)) reader_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ready_i   (rdy),
        .meta_i    (ctl_q.meta),
        .rdata_i   (rd_data),
        .rslot_o   (rd_slot),
        .ridx_o    (rd_idx),
        .done_o    (rd_done),
        .out_valid (out_valid),
        .out_sof   (out_sof),
        .out_eof   (out_eof),
        .out_den   (out_den),
        .out_err   (out_err),
        .out_data  (out_data)
    );

    // payload word counts for the last and the held cell of a frame
    always_comb begin
        p_w     = (CW'(ctl_q.len) + CW'(3)) >> 2;
        fw_w    = CW'(ctl_q.fw);
        d_last  = p_w - fw_w;
        d_pen   = p_w + CW'(CELL_WORDS) - fw_w;
        if (p_w <= fw_w)             pw_last = '0;
        else if (d_last > CW'(TRL_A)) pw_last = IDX_W'(TRL_A);
        else                         pw_last = d_last[IDX_W-1:0];
        if (p_w + CW'(CELL_WORDS) <= fw_w)  pw_pen = '0;
        else if (d_pen > CW'(CELL_WORDS))   pw_pen = IDX_W'(CELL_WORDS);
        else                                pw_pen = d_pen[IDX_W-1:0];
        len_big = CW'(ctl_q.len) > ((fw_w + CW'(TRL_A)) << 2);
        crc_bad = crc_nx != CRC_RESIDUE;
    end

    always_comb begin
        ctl_d  = ctl_q;
        mem_we = 1'b0;
        for (int i = 0; i < NSLOT; i++) begin
            if (rd_done && rd_slot == SLOT_W'(i)) ctl_d.st[i] = S_FREE;
        end
        if (in_valid && in_soc) begin
            ctl_d.in_cell   = 1'b1;
            ctl_d.wc        = '0;
            ctl_d.cell_last = in_data[1];
            ctl_d.st[ctl_q.wslot]         = S_FILL;
            ctl_d.meta[ctl_q.wslot]       = '0;
            ctl_d.meta[ctl_q.wslot].first = ctl_q.frame_start;
            if (ctl_q.frame_start) begin
                ctl_d.crc = '1;
                ctl_d.fw  = '0;
            end
        end else if (in_valid && ctl_q.in_cell) begin
            mem_we   = 1'b1;
            ctl_d.crc = crc_nx;
            ctl_d.wc  = ctl_q.wc + 1'b1;
            if (ctl_q.wc == IDX_W'(TRL_A)) ctl_d.len = in_data[LEN_W-1:0];
            if (ctl_q.wc == IDX_W'(TRL_B)) begin
                ctl_d.in_cell = 1'b0;
                ctl_d.wslot   = (ctl_q.wslot == SLOT_W'(NSLOT - 1)) ? '0 : ctl_q.wslot + 1'b1;
                if (!ctl_q.cell_last) begin
                    if (ctl_q.held_vld) begin
                        ctl_d.meta[ctl_q.held].pw = IDX_W'(CELL_WORDS);
                        ctl_d.st[ctl_q.held]      = S_READY;
                    end
                    ctl_d.held        = ctl_q.wslot;
                    ctl_d.held_vld    = 1'b1;
                    ctl_d.st[ctl_q.wslot] = S_HELD;
                    ctl_d.fw          = ctl_q.fw + FW_W'(CELL_WORDS);
                    ctl_d.frame_start = 1'b0;
                end else begin
                    ctl_d.meta[ctl_q.wslot].last    = 1'b1;
                    ctl_d.meta[ctl_q.wslot].pw      = pw_last;
                    ctl_d.meta[ctl_q.wslot].has_eof = (pw_last != '0);
                    ctl_d.meta[ctl_q.wslot].err     = crc_bad || len_big;
                    ctl_d.st[ctl_q.wslot]           = S_READY;
                    if (ctl_q.held_vld) begin
                        ctl_d.meta[ctl_q.held].pw      = pw_pen;
                        ctl_d.meta[ctl_q.held].has_eof = (pw_last == '0);
                        ctl_d.st[ctl_q.held]           = S_READY;
                    end
                    ctl_d.held_vld    = 1'b0;
                    ctl_d.frame_start = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q             <= '0;
            ctl_q.frame_start <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // a new cell must find its slot drained by the reader
    assert_slot_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_soc) |->
        (ctl_q.st[ctl_q.wslot] == S_FREE || (rd_done && rd_slot == ctl_q.wslot)));
endmodule

// File: tb/aal5rx_frame_rx_tb.sv
module aal5rx_frame_rx_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MAXW = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_soc = 1'b0;
    logic [31:0] in_data = '0;
    logic        out_valid, out_sof, out_eof, out_den, out_err;
    logic [31:0] out_data;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [31:0] exp_data [MAXW];
    logic [3:0]  exp_flg  [MAXW];
    logic [31:0] cap_data [MAXW];
    logic [3:0]  cap_flg  [MAXW];
    int exp_n = 0;
    int cap_n = 0;
    logic [7:0] pdu [0:255];

    aal5rx_frame_rx dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_soc(in_soc),
        .in_data(in_data), .out_valid(out_valid), .out_sof(out_sof),
        .out_eof(out_eof), .out_den(out_den), .out_err(out_err), .out_data(out_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (rst_n && out_valid && cap_n < MAXW) begin
            cap_data[cap_n] = out_data;
            cap_flg[cap_n]  = {out_sof, out_eof, out_den, out_err};
            cap_n++;
        end
    end

    function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] b);
        logic fb;
        for (int k = 7; k >= 0; k--) begin
            fb = c[31] ^ b[k];
            c  = {c[30:0], 1'b0};
            if (fb) c = c ^ 32'h04C11DB7;
        end
        return c;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            in_valid = 1'b0; in_soc = 1'b0;
        end
    endtask

    task automatic put_word(input logic soc, input logic [31:0] w, input bit gaps, input int k);
        if (gaps && (k % 5 == 3)) idle(2);
        @(posedge clk); #1;
        in_valid = 1'b1; in_soc = soc; in_data = w;
    endtask

    // builds a frame of lr payload octets with length field lf, queues the
    // expected output and sends the cells
    task automatic send_frame(input int lr, input int lf, input bit corrupt,
                              input bit gaps, input int seed);
        int cells, tot, np, ncrc;
        logic [31:0] c;
        cells = (lr + 8 + 47) / 48;
        tot   = cells * 48;
        for (int i = 0; i < tot; i++) pdu[i] = 8'h00;
        for (int i = 0; i < lr; i++) pdu[i] = 8'((seed + i * 7) & 8'hFF);
        pdu[tot-8] = 8'h5A;
        pdu[tot-7] = 8'h00;
        pdu[tot-6] = 8'(lf >> 8);
        pdu[tot-5] = 8'(lf);
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < tot - 4; i++) c = crc_byte(c, pdu[i]);
        c = ~c;
        {pdu[tot-4], pdu[tot-3], pdu[tot-2], pdu[tot-1]} = c;
        if (corrupt) pdu[0] = pdu[0] ^ 8'h01;
        ncrc = cells * 12 - 2;
        np = (lf + 3) / 4;
        if (np > ncrc) np = ncrc;
        for (int w = 0; w < np; w++) begin
            exp_data[exp_n] = {pdu[4*w], pdu[4*w+1], pdu[4*w+2], pdu[4*w+3]};
            exp_flg[exp_n]  = {w == 0, w == np - 1, 1'b1, 1'b0};
            exp_n++;
        end
        for (int w = ncrc; w < ncrc + 2; w++) begin
            exp_data[exp_n] = {pdu[4*w], pdu[4*w+1], pdu[4*w+2], pdu[4*w+3]};
            exp_flg[exp_n]  = {3'b000, (w == ncrc + 1) && (corrupt || lf > tot - 8)};
            exp_n++;
        end
        for (int cc = 0; cc < cells; cc++) begin
            put_word(1'b1, 32'h0010_0020 | ((cc == cells - 1) ? 32'h2 : 32'h0), gaps, 0);
            for (int w = 0; w < 12; w++) begin
                int b;
                b = cc * 48 + w * 4;
                put_word(1'b0, {pdu[b], pdu[b+1], pdu[b+2], pdu[b+3]}, gaps, w + 1);
            end
        end
    endtask

    task automatic start_case();
        exp_n = 0;
        cap_n = 0;
    endtask

    task automatic compare_stream(input string tag);
        idle(120);
        check(cap_n == exp_n, tag, "word count", 36'(cap_n), 36'(exp_n));
        for (int i = 0; i < exp_n && i < cap_n; i++) begin
            check(cap_data[i] == exp_data[i] && cap_flg[i] == exp_flg[i], tag,
                  $sformatf("word %0d {sof,eof,den,err,data}", i),
                  {cap_flg[i], cap_data[i]}, {exp_flg[i], exp_data[i]});
        end
    endtask

    task automatic t_reset();
        check({out_valid, out_sof, out_eof, out_den, out_err} == 5'b0, "R1",
              "outputs after reset", 36'({out_valid, out_sof, out_eof, out_den, out_err}), 36'h0);
    endtask

    task automatic t_single_full();
        start_case();
        send_frame(40, 40, 1'b0, 1'b0, 3);   // R3 R4: payload fills up to the trailer
        compare_stream("R3 R4");
    endtask

    task automatic t_single_partial();
        start_case();
        send_frame(13, 13, 1'b0, 1'b0, 11);  // R5: partial word, padding words dropped
        compare_stream("R5 R6");
    endtask

    task automatic t_multi();
        start_case();
        send_frame(100, 100, 1'b0, 1'b0, 21); // R2: only the flagged cell ends the frame
        compare_stream("R2 R3");
    endtask

    task automatic t_spill();
        start_case();
        send_frame(41, 41, 1'b0, 1'b0, 5);    // R10: eof in the next-to-last cell
        compare_stream("R10");
    endtask

    task automatic t_crc_bad();
        start_case();
        send_frame(30, 30, 1'b1, 1'b0, 9);
        compare_stream("R7");
    endtask

    task automatic t_len_bad();
        start_case();
        send_frame(20, 60, 1'b0, 1'b0, 17);
        compare_stream("R8");
    endtask

    task automatic t_back_to_back();
        start_case();
        send_frame(60, 60, 1'b0, 1'b0, 1);
        send_frame(8, 8, 1'b0, 1'b0, 2);
        send_frame(90, 90, 1'b0, 1'b0, 4);
        send_frame(41, 41, 1'b0, 1'b0, 6);
        send_frame(40, 40, 1'b0, 1'b0, 8);
        compare_stream("R9 R6");
    endtask

    task automatic t_gaps();
        start_case();
        send_frame(70, 70, 1'b0, 1'b1, 13);
        compare_stream("R9");
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/2);
        t_reset();
        #1 rst_n = 1'b1;
        idle(2);
        t_reset();
        t_single_full();
        t_single_partial();
        t_multi();
        t_spill();
        t_crc_bad();
        t_len_bad();
        t_back_to_back();
        t_gaps();
        finish_run();
    end
endmodule